// File: doc/BRIEF.md
# Receiver Bring-Up and Word-Alignment Sequencer

This block is the control sequencer for a multi-lane serial receiver. It drives the four reset lines of the receive path: the clock-synthesizer reset, the phase-aligner reset, the retiming-FIFO reset and the slip-logic reset. It watches the synthesizer lock and the per-lane phase-lock inputs, and it steps the receiver from power-up to a state where every lane delivers whole words. It then aligns the lanes one at a time. For each lane it compares the parallel word against a fixed control character and pulses that lane's slip output until the two match.

Two operating modes are supported, and one input picks between them. In phase-aligned mode the sequencer releases the aligner once the synthesizer lock has been steady for a set time. It then waits for every lane to lock and pulses the FIFO reset before the slip reset. In plain mode the aligner and FIFO steps are skipped, and the sequence goes straight from a steady lock to the slip reset. If a lane exhausts its slip budget without a match, the sequencer flags that lane and retries from the aligner reset.

Top module: `rx_init_seq`

## Requirements
- R1: After reset, or in the cycle after `reinit_req` is sampled high, `pll_rst` and `align_rst` are both high, `fifo_rst`, `slip_rst`, `ready` and every `slip_pulse` bit are low, and `lane_fail` is cleared. `pll_rst` then stays high for exactly PLL_HOLD_CYC (4) cycles.
- R2: Once `pll_rst` is low, the lock counts as steady only after `pll_locked` has been sampled high on LOCK_STABLE_CYC (256) consecutive edges. A single low sample restarts the count. The next step starts in the cycle after the 256th high sample.
- R3: In phase-aligned mode (`use_phase_align`=1), `align_rst` falls when the lock becomes steady. `fifo_rst` stays low until every `lane_locked` bit is high, rises in the cycle after the last lane locks, and stays high for exactly FIFO_RST_CYC (2) cycles.
- R4: In plain mode (`use_phase_align`=0), `fifo_rst` is never asserted and `align_rst` stays high. `slip_rst` rises in the cycle after the lock becomes steady.
- R5: `slip_rst` stays high for exactly SLIP_RST_CYC (2) cycles. In phase-aligned mode it rises in the cycle right after `fifo_rst` falls.
- R6: Lanes are aligned in ascending order. Lane i's word is `rx_word[i*WORD_W +: WORD_W]`, and the control character is ALIGN_CHAR (8'hBC). While the lane's word mismatches, one-cycle slip pulses are sent on `slip_pulse[i]`. A lane whose word matches after k slips receives exactly k pulses, and at most one `slip_pulse` bit is high at a time.
- R7: After each slip pulse, at least SETTLE_CYC (5) cycles pass before the word is compared again. Consecutive slip pulses are therefore at least SETTLE_CYC+1 cycles apart.
- R8: `ready` is low until the last lane matches. It then rises and stays high, with all resets and slips idle, until `reinit_req`.
- R9: If a lane's word still mismatches after SLIP_ROLLOVER (10) slips, its `lane_fail` bit is set and `align_rst` is asserted again. The sequence restarts from the aligner reset, which includes the FIFO reset in phase-aligned mode. `lane_fail` bits stay set until reset or `reinit_req`.
- R10: `use_phase_align` is captured only while `pll_rst` is high. Changes after that do not affect the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel (core) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reinit_req | input | 1 | Restart the whole bring-up |
| use_phase_align | input | 1 | 1 = phase-aligned mode, 0 = plain mode |
| pll_locked | input | 1 | Clock synthesizer lock |
| lane_locked | input | LANES | Per-lane phase-aligner lock |
| rx_word | input | LANES*WORD_W | Received parallel words, lane i at bits i*WORD_W upward |
| pll_rst | output | 1 | Clock synthesizer reset |
| align_rst | output | 1 | Phase-aligner reset |
| fifo_rst | output | 1 | Retiming FIFO reset |
| slip_rst | output | 1 | Slip-logic reset |
| slip_pulse | output | LANES | One-cycle slip request per lane |
| ready | output | 1 | All lanes aligned |
| lane_fail | output | LANES | Sticky per-lane slip-budget exhaustion |

## Verification
The assertions assume that the lane locks stay high while the FIFO reset runs. They also assume that `pll_locked` is only trusted once `pll_rst` is low. The stimulus meets both: it drops the locks only at a re-initialization and raises them only after the matching reset has fallen. The stimulus model counts the slip pulses on each lane, with a wrap at the rollover value, and presents the control character only at a chosen slip count. The random choices of slip targets, lock delays and mode therefore keep every lane reachable, except in the one directed case that forces a rollover failure.

// File: rtl/rx_init_pkg.sv
// Shared types for the receiver bring-up sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package rx_init_pkg;

    typedef enum logic [2:0] {
        ST_PLL_RST,
        ST_WAIT_LOCK,
        ST_PHASE_RST,
        ST_WAIT_PHASE,
        ST_FIFO_RST,
        ST_SLIP_RST,
        ST_ALIGN,
        ST_READY
    } seq_state_t;

    typedef enum logic [1:0] {
        SR_CMP,
        SR_PULSE,
        SR_WAIT
    } srch_state_t;

endpackage

// File: rtl/rx_init_lock_qual.sv
// Lock qualifier: reports a steady lock after STABLE_CYC consecutive high
// samples of lock_in. Any low sample, or clr, restarts the count.
// Assumes lock_in is already synchronous to clk.
module rx_init_lock_qual #(
    parameter int unsigned STABLE_CYC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic lock_in,
    output logic stable
);
    localparam int unsigned CW = $clog2(STABLE_CYC + 1);

    logic [CW-1:0] cnt;

    // Count consecutive high samples, saturating at the target.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !lock_in)
            cnt <= '0;
        else if (cnt != CW'(STABLE_CYC))
            cnt <= cnt + 1'b1;
    end

    assign stable = lock_in && (cnt == CW'(STABLE_CYC));

    AST_DROP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_in |=> !stable); // R2

endmodule

// File: rtl/rx_init_lane_mux.sv
// Lane selector: routes the selected lane's word to the search logic and
// fans the single slip request out to that lane only.
// Assumes sel < LANES.
module rx_init_lane_mux #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned WORD_W = 8,
    localparam int unsigned IW    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [IW-1:0]           sel,
    input  logic [LANES*WORD_W-1:0] words,
    input  logic                    slip_in,
    output logic [WORD_W-1:0]       word_out,
    output logic [LANES-1:0]        slip_out
);
    // Pick the selected lane's word.
    assign word_out = words[sel*WORD_W +: WORD_W];

    // Demultiplex the slip request, one gate per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_slip
        assign slip_out[g] = slip_in && (sel == IW'(g));
    end

endmodule

// File: rtl/rx_init_slip_search.sv
// Slip search for one lane at a time: compares the word with CHAR, and on a
// mismatch issues one slip pulse, waits SETTLE_CYC cycles and compares again.
// Reports a match, or a failure once ROLLOVER slips have not produced a match.
// Assumes the caller drops 'active' to restart it and changes lanes only
// on a match.
module rx_init_slip_search
    import rx_init_pkg::*;
#(
    parameter int unsigned          WORD_W     = 8,
    parameter logic [WORD_W-1:0]    CHAR       = 'hBC,
    parameter int unsigned          SETTLE_CYC = 5,
    parameter int unsigned          ROLLOVER   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [WORD_W-1:0] word,
    output logic              slip,
    output logic              match,
    output logic              fail
);
    localparam int unsigned SW = $clog2(ROLLOVER + 1);
    localparam int unsigned WW = $clog2(SETTLE_CYC + 1);
    localparam int unsigned GW = $clog2(SETTLE_CYC + 3);

    srch_state_t   st;
    logic [SW-1:0] slips;
    logic [WW-1:0] wt;
    logic          hit;

    assign hit   = (word == CHAR);
    assign match = active && (st == SR_CMP) && hit;
    assign fail  = active && (st == SR_CMP) && !hit && (slips == SW'(ROLLOVER));
    assign slip  = active && (st == SR_PULSE);

    // Compare / pulse / settle loop with a slip budget.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            st    <= SR_CMP;
            slips <= '0;
            wt    <= '0;
        end else begin
            case (st)
                SR_CMP: begin
                    if (match || fail) slips <= '0;
                    else               st    <= SR_PULSE;
                end
                SR_PULSE: begin
                    slips <= slips + 1'b1;
                    wt    <= '0;
                    st    <= SR_WAIT;
                end
                default: begin
                    if (wt == WW'(SETTLE_CYC - 1)) st <= SR_CMP;
                    else                           wt <= wt + 1'b1;
                end
            endcase
        end
    end

    // Checker state: cycles since the previous slip pulse.
    logic [GW-1:0] since;
    logic          seen;
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            since <= '0;
            seen  <= 1'b0;
        end else if (slip) begin
            since <= GW'(1);
            seen  <= 1'b1;
        end else if (since != GW'(SETTLE_CYC + 2)) begin
            since <= since + 1'b1;
        end
    end

    AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        slip |-> (!seen || since >= GW'(SETTLE_CYC + 1))); // R7

    AST_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        slip |-> slips < SW'(ROLLOVER)); // R9

endmodule

// File: rtl/rx_init_seq.sv
// Receiver bring-up sequencer. Order: synthesizer reset, steady-lock wait,
// then (phase-aligned mode) aligner release, all-lane lock wait and FIFO
// reset pulse, then slip reset, lane-by-lane word search and ready.
// A slip-budget failure flags the lane and restarts from the aligner reset.
// Assumes all inputs are synchronous to clk.
module rx_init_seq
    import rx_init_pkg::*;
#(
    parameter int unsigned       LANES           = 4,
    parameter int unsigned       WORD_W          = 8,
    parameter logic [WORD_W-1:0] ALIGN_CHAR      = 'hBC,
    parameter int unsigned       PLL_HOLD_CYC    = 4,
    parameter int unsigned       LOCK_STABLE_CYC = 256,
    parameter int unsigned       FIFO_RST_CYC    = 2,
    parameter int unsigned       SLIP_RST_CYC    = 2,
    parameter int unsigned       SETTLE_CYC      = 5,
    parameter int unsigned       SLIP_ROLLOVER   = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reinit_req,
    input  logic                    use_phase_align,
    input  logic                    pll_locked,
    input  logic [LANES-1:0]        lane_locked,
    input  logic [LANES*WORD_W-1:0] rx_word,
    output logic                    pll_rst,
    output logic                    align_rst,
    output logic                    fifo_rst,
    output logic                    slip_rst,
    output logic [LANES-1:0]        slip_pulse,
    output logic                    ready,
    output logic [LANES-1:0]        lane_fail
);
    localparam int unsigned IW   = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int unsigned MAXA = (PLL_HOLD_CYC > FIFO_RST_CYC) ? PLL_HOLD_CYC : FIFO_RST_CYC;
    localparam int unsigned MAXH = (MAXA > SLIP_RST_CYC) ? MAXA : SLIP_RST_CYC;
    localparam int unsigned TW   = $clog2(MAXH + 1);
    localparam int unsigned HW   = $clog2(PLL_HOLD_CYC + 1);

    seq_state_t        st, st_nxt;
    logic [TW-1:0]     tmr;
    logic [IW-1:0]     lane_idx;
    logic              phase_mode;
    logic [LANES-1:0]  fail_q;
    logic              lock_stable;
    logic              srch_active, srch_slip, srch_match, srch_fail;
    logic [WORD_W-1:0] sel_word;
    logic              last_lane;

    assign srch_active = (st == ST_ALIGN);
    assign last_lane   = (lane_idx == IW'(LANES - 1));

    rx_init_lock_qual #(.STABLE_CYC(LOCK_STABLE_CYC)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pll_rst),
        .lock_in (pll_locked),
        .stable  (lock_stable)
    );

    rx_init_lane_mux #(.LANES(LANES), .WORD_W(WORD_W)) u_mux (
        .sel      (lane_idx),
        .words    (rx_word),
        .slip_in  (srch_slip),
        .word_out (sel_word),
        .slip_out (slip_pulse)
    );

    rx_init_slip_search #(
        .WORD_W     (WORD_W),
        .CHAR       (ALIGN_CHAR),
        .SETTLE_CYC (SETTLE_CYC),
        .ROLLOVER   (SLIP_ROLLOVER)
    ) u_srch (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (srch_active),
        .word   (sel_word),
        .slip   (srch_slip),
        .match  (srch_match),
        .fail   (srch_fail)
    );

    // Next-state selection for the bring-up order.
    always_comb begin
        st_nxt = st;
        case (st)
            ST_PLL_RST:    if (tmr == TW'(PLL_HOLD_CYC - 1)) st_nxt = ST_WAIT_LOCK;
            ST_WAIT_LOCK:  if (lock_stable) st_nxt = phase_mode ? ST_WAIT_PHASE : ST_SLIP_RST;
            ST_PHASE_RST:  st_nxt = phase_mode ? ST_WAIT_PHASE : ST_SLIP_RST;
            ST_WAIT_PHASE: if (&lane_locked) st_nxt = ST_FIFO_RST;
            ST_FIFO_RST:   if (tmr == TW'(FIFO_RST_CYC - 1)) st_nxt = ST_SLIP_RST;
            ST_SLIP_RST:   if (tmr == TW'(SLIP_RST_CYC - 1)) st_nxt = ST_ALIGN;
            ST_ALIGN: begin
                if (srch_fail)                    st_nxt = ST_PHASE_RST;
                else if (srch_match && last_lane) st_nxt = ST_READY;
            end
            default: st_nxt = ST_READY;
        endcase
        if (reinit_req) st_nxt = ST_PLL_RST;
    end

    // State, step timer and captured mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_PLL_RST;
            tmr        <= '0;
            phase_mode <= 1'b1;
        end else begin
            st <= st_nxt;
            if (st_nxt != st || reinit_req) tmr <= '0;
            else if (tmr != {TW{1'b1}})     tmr <= tmr + 1'b1;
            if (st == ST_PLL_RST) phase_mode <= use_phase_align;
        end
    end

    // Lane pointer: walks up on each match while aligning.
    always_ff @(posedge clk) begin
        if (!rst_n || st != ST_ALIGN)
            lane_idx <= '0;
        else if (srch_match && !last_lane)
            lane_idx <= lane_idx + 1'b1;
    end

    // Sticky per-lane failure flags, cleared by a full restart.
    always_ff @(posedge clk) begin
        if (!rst_n || reinit_req) begin
            fail_q <= '0;
        end else if (srch_fail) begin
            for (int i = 0; i < LANES; i++)
                if (lane_idx == IW'(i)) fail_q[i] <= 1'b1;
        end
    end

    assign pll_rst   = (st == ST_PLL_RST);
    assign align_rst = !phase_mode || (st == ST_PLL_RST) ||
                       (st == ST_WAIT_LOCK) || (st == ST_PHASE_RST);
    assign fifo_rst  = (st == ST_FIFO_RST);
    assign slip_rst  = (st == ST_SLIP_RST);
    assign ready     = (st == ST_READY);
    assign lane_fail = fail_q;

    // Checker state: length of the current synthesizer-reset run.
    logic [HW-1:0] hold_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || !pll_rst)               hold_cnt <= '0;
        else if (hold_cnt != HW'(PLL_HOLD_CYC)) hold_cnt <= hold_cnt + 1'b1;
    end

    AST_PLL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_rst) |-> hold_cnt >= HW'(PLL_HOLD_CYC)); // R1

    AST_RESETS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst |-> align_rst && !fifo_rst && !slip_rst && !ready); // R1

    AST_ALIGN_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(align_rst) |-> $past(pll_locked) && !pll_rst); // R2

    AST_FIFO_AFTER_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_rst) |-> $past(&lane_locked) && !align_rst); // R3

    AST_ONE_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slip_pulse)); // R6

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> slip_pulse == '0 && !fifo_rst && !slip_rst && !pll_rst); // R8

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reinit_req) |-> (lane_fail & $past(lane_fail)) == $past(lane_fail)); // R9

endmodule

// File: tb/sim_rx_init_seq.sv
`timescale 1ns/1ps
module sim_rx_init_seq;
    localparam int LN    = 4;
    localparam int WW    = 8;
    localparam logic [7:0] CH = 8'hBC;
    localparam int HOLD  = 4;
    localparam int STAB  = 256;
    localparam int FRST  = 2;
    localparam int SRST  = 2;
    localparam int SETL  = 5;
    localparam int ROLL  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reinit_req = 1'b0;
    logic use_phase_align = 1'b1;
    logic pll_locked = 1'b0;
    logic [LN-1:0] lane_locked = '0;
    logic [LN*WW-1:0] rx_word;
    logic pll_rst, align_rst, fifo_rst, slip_rst, ready;
    logic [LN-1:0] slip_pulse, lane_fail;

    always #2 clk = ~clk;

    rx_init_seq u0 (
        .clk(clk), .rst_n(rst_n), .reinit_req(reinit_req),
        .use_phase_align(use_phase_align), .pll_locked(pll_locked),
        .lane_locked(lane_locked), .rx_word(rx_word),
        .pll_rst(pll_rst), .align_rst(align_rst), .fifo_rst(fifo_rst),
        .slip_rst(slip_rst), .slip_pulse(slip_pulse), .ready(ready),
        .lane_fail(lane_fail)
    );

    int checks = 0;
    int fails  = 0;
    int kreq[LN];
    int mcnt[LN];
    int pulses[LN];
    int maxlane;
    int cyc = 0;
    int last_pulse;
    int fifo_seen = 0;

    // Deserializer model: the control character appears at the target slip count.
    always_comb begin
        for (int i = 0; i < LN; i++)
            rx_word[i*WW +: WW] = (mcnt[i] == kreq[i]) ? CH : ~CH;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_pulses(input int k);
        return (k < ROLL) ? k : ROLL;
    endfunction

    // Monitor: slip counting, lane order, pulse spacing.
    always @(negedge clk) begin
        cyc++;
        if (fifo_rst) fifo_seen++;
        if (slip_rst) begin
            for (int i = 0; i < LN; i++) begin mcnt[i] = 0; pulses[i] = 0; end
            maxlane = 0;
            last_pulse = -1;
        end
        for (int i = 0; i < LN; i++) begin
            if (slip_pulse[i]) begin
                pulses[i]++;
                mcnt[i] = (mcnt[i] + 1) % ROLL;
                if (i < maxlane) chk(0, "R6 lane order", i, maxlane);
                maxlane = i;
                if (last_pulse >= 0)
                    chk(cyc - last_pulse >= SETL + 1, "R7 slip gap", cyc - last_pulse, SETL + 1);
                last_pulse = cyc;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic run_round(input bit mode, input bit glitch, input int fail_lane);
        int n;
        bit did_fail;
        // R1: restart request
        pll_locked = 0; lane_locked = '0; use_phase_align = mode;
        reinit_req = 1;
        @(negedge clk);
        reinit_req = 0;
        chk(align_rst == 1, "R1 align_rst with pll_rst", align_rst, 1);
        chk(lane_fail == 0, "R1 lane_fail cleared", lane_fail, 0);
        chk(ready == 0 && fifo_rst == 0 && slip_rst == 0 && slip_pulse == 0,
            "R1 outputs idle", ready, 0);
        n = 0;
        while (pll_rst) begin n++; @(negedge clk); end
        chk(n == HOLD, "R1 pll_rst hold", n, HOLD);
        use_phase_align = !mode; // R10: must be ignored from here on
        repeat ($urandom_range(1, 20)) @(negedge clk);
        pll_locked = 1;
        if (glitch) begin
            repeat (100) @(negedge clk);
            chk(align_rst == 1, "R2 no early release", align_rst, 1);
            pll_locked = 0;
            @(negedge clk);
            pll_locked = 1;
        end
        n = 0;
        @(negedge clk);
        if (mode) while (align_rst) begin n++; @(negedge clk); end
        else      while (!slip_rst) begin n++; @(negedge clk); end
        chk(n == STAB, "R2 R10 steady lock count", n, STAB);
        if (mode) begin
            for (int j = 0; j < LN; j++) begin
                repeat ($urandom_range(1, 5)) begin
                    chk(fifo_rst == 0, "R3 fifo waits for all lanes", fifo_rst, 0);
                    @(negedge clk);
                end
                lane_locked[j] = 1;
            end
            @(negedge clk);
            chk(fifo_rst == 1, "R3 fifo after last lane", fifo_rst, 1);
            n = 0;
            while (fifo_rst) begin n++; @(negedge clk); end
            chk(n == FRST, "R3 fifo pulse length", n, FRST);
            chk(slip_rst == 1, "R5 slip after fifo", slip_rst, 1);
        end else begin
            fifo_seen = 0;
            chk(align_rst == 1, "R4 R10 aligner held in plain mode", align_rst, 1);
        end
        n = 0;
        while (slip_rst) begin n++; @(negedge clk); end
        chk(n == SRST, "R5 slip_rst length", n, SRST);
        did_fail = 0;
        while (!ready) begin
            chk(ready == 0, "R8 not ready early", ready, 0);
            if (fail_lane >= 0 && !did_fail && lane_fail[fail_lane]) begin
                did_fail = 1;
                chk(pulses[fail_lane] == ROLL, "R9 slips before fail", pulses[fail_lane], ROLL);
                chk(align_rst == 1, "R9 aligner reset again", align_rst, 1);
                n = fifo_seen;
                kreq[fail_lane] = 3;
                while (!slip_rst) @(negedge clk);
                chk(fifo_seen > n, "R9 fifo reset on retry", fifo_seen - n, 2);
            end
            @(negedge clk);
        end
        if (!mode) chk(fifo_seen == 0, "R4 no fifo reset", fifo_seen, 0);
        if (fail_lane >= 0) begin
            chk(did_fail, "R9 fail seen", did_fail, 1);
            chk(lane_fail == LN'(1 << fail_lane), "R9 sticky flag", lane_fail, 1 << fail_lane);
        end
        for (int i = 0; i < LN; i++)
            chk(pulses[i] == exp_pulses(kreq[i]), "R6 slip count", pulses[i], exp_pulses(kreq[i]));
        repeat (20) @(negedge clk);
        chk(ready == 1 && slip_pulse == 0, "R8 ready holds", ready, 1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < LN; i++) begin kreq[i] = 0; mcnt[i] = 0; pulses[i] = 0; end
        maxlane = 0; last_pulse = -1;
        repeat (3) @(negedge clk);
        chk(pll_rst == 1 && align_rst == 1, "R1 reset resets high", pll_rst, 1);
        chk(fifo_rst == 0 && slip_rst == 0 && ready == 0, "R1 reset others low", ready, 0);
        chk(slip_pulse == 0 && lane_fail == 0, "R1 reset slip/fail", lane_fail, 0);
        rst_n = 1;
        @(negedge clk);
        // Directed: phase mode, lock glitch, no slips needed.
        run_round(1'b1, 1'b1, -1);
        // Directed: plain mode, max reachable slips on every lane.
        for (int i = 0; i < LN; i++) kreq[i] = ROLL - 1;
        run_round(1'b0, 1'b0, -1);
        // Directed: rollover failure on lane 2.
        kreq[0] = 1; kreq[1] = 0; kreq[2] = ROLL; kreq[3] = 2;
        run_round(1'b1, 1'b0, 2);
        // Random rounds.
        for (int r = 0; r < 5; r++) begin
            for (int i = 0; i < LN; i++) kreq[i] = $urandom_range(0, ROLL - 1);
            run_round(1'($urandom_range(0, 1)), 1'b0, -1);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule